// File: doc/BRIEF.md
# Flash Page Hamming Syndrome Corrector

This block checks one 512-byte flash data block against its 24-bit row/column parity code. It XORs the code read back from the spare area with the code recomputed over the data as it streamed past. From that syndrome it decides one of four outcomes: the data is clean; a single data bit is wrong (and where); a single bit of the stored code itself is wrong; or the damage cannot be repaired. A page that was never programmed reads back as all ones. When the caller asks for it, such a code is taken as clean, so erased pages do not raise false alarms.

A controller pulses `start` with both codes present. One clock later the block holds the verdict and the error location in registers and pulses `done`. The verdict stays until the next `start`. While the data buffer is read back, the controller can pass each byte and its index through the correction port. Only the byte at the registered error location comes back with one bit inverted. The parity generator and the data buffer are outside this block.

Top module: `hecc_corrector`

## Requirements
- R1: The syndrome is `stored_code ^ calc_code`. Lane d0 is bits 7:0, d1 is bits 15:8 and d2 is bits 23:16. A zero syndrome gives status 2'b00 (clean).
- R2: If `ignore_blank` is 1 and `stored_code` is 24'hFFFFFF, the status is 2'b00 whatever the syndrome. This check has priority over every case below.
- R3: The syndrome is a correctable data error when, in every lane, bits 1:0, 3:2, 5:4 and 7:6 each hold unequal values. The status is then 2'b01.
- R4: For status 2'b01, `err_bit` bits 2, 1 and 0 equal d2 bits 7, 5 and 3.
- R5: For status 2'b01, `err_byte` bit 8 equals d2 bit 1. Bits 7..4 equal d1 bits 7, 5, 3, 1, and bits 3..0 equal d0 bits 7, 5, 3, 1.
- R6: A syndrome with exactly one bit set gives status 2'b10 (error in the stored code only).
- R7: Any other non-zero syndrome gives status 2'b11 (uncorrectable).
- R8: Results are registered on the clock edge where `start` is high. `done` is high for exactly the following cycle. Without `start`, the status and location outputs keep their values whatever the code inputs do.
- R9: `fix_out` equals `fix_in` with bit `err_bit` inverted when the status is 2'b01 and `fix_idx` equals `err_byte`. In every other case `fix_out` equals `fix_in`.
- R10: After reset, the status is 2'b00, `err_byte` and `err_bit` are 0, and `done` is 0.
- R11: `err_byte` and `err_bit` are 0 whenever the status is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the codes on this edge |
| ignore_blank | input | 1 | Treat an all-ones stored code as an erased page |
| stored_code | input | 24 | Code read back from flash, lanes d0..d2 from the low byte up |
| calc_code | input | 24 | Code recomputed over the data block |
| status | output | 2 | 00 clean, 01 data fixed, 10 code-only error, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the faulty data bit |
| err_bit | output | 3 | Bit index inside that byte |
| done | output | 1 | One-cycle pulse after `start` |
| fix_in | input | 8 | Data byte to pass through the correction path |
| fix_idx | input | 9 | Index of `fix_in` within the block |
| fix_out | output | 8 | Byte after correction |

## Verification
A wrong verdict or location shows up on `status`, `err_byte` and `err_bit` in the cycle right after `start`. The same fault then corrupts `fix_out` for the addressed byte, or for a byte that should have passed unchanged. Because the registers hold the verdict, a load that leaks through without `start` shows up as outputs changing while the code inputs move and `start` stays low. The vector table covers every classification branch and the lane bit mapping at both extreme addresses. Swept locations then confirm the index mapping bit by bit through the correction port.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_CODE  = 2'b10,
        ST_BAD   = 2'b11
    } hecc_status_e;

endpackage

// File: rtl/hecc_syndrome.sv
// Lane-wise XOR of the two codes, plus the per-lane pair test that marks a
// syndrome as a single data-bit error pattern.
module hecc_syndrome #(
    parameter int LANES  = 3,
    parameter int LANE_W = 8,
    localparam int SYN_W = LANES * LANE_W,
    localparam int PAIRS = LANE_W / 2
) (
    input  logic [SYN_W-1:0] stored_code,
    input  logic [SYN_W-1:0] calc_code,
    output logic [SYN_W-1:0] syn,
    output logic             pairs_split,
    output logic             single_bit,
    output logic             stored_blank
);

    logic [LANES-1:0] lane_ok;

    assign syn = stored_code ^ calc_code;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PAIRS-1:0] pair_diff;
        for (genvar k = 0; k < PAIRS; k++) begin : g_pair
            assign pair_diff[k] = syn[l*LANE_W + 2*k + 1] ^ syn[l*LANE_W + 2*k];
        end
        assign lane_ok[l] = &pair_diff;
    end

    assign pairs_split  = &lane_ok;
    assign single_bit   = (syn != '0) && ((syn & (syn - SYN_W'(1))) == '0);
    assign stored_blank = &stored_code;

endmodule

// File: rtl/hecc_classify.sv
// Priority decision from syndrome flags to the status code.
module hecc_classify
    import hecc_pkg::*;
(
    input  logic         syn_zero,
    input  logic         ignore_blank,
    input  logic         stored_blank,
    input  logic         pairs_split,
    input  logic         single_bit,
    output hecc_status_e verdict
);

    always_comb begin
        if (syn_zero) begin
            verdict = ST_CLEAN;
        end else if (ignore_blank && stored_blank) begin
            verdict = ST_CLEAN;
        end else if (pairs_split) begin
            verdict = ST_FIXED;
        end else if (single_bit) begin
            verdict = ST_CODE;
        end else begin
            verdict = ST_BAD;
        end
    end

endmodule

// File: rtl/hecc_locate.sv
// Gathers the odd-position syndrome bits into the byte and bit address.
// The low lanes give four byte-address bits each. The top lane's lowest odd bit
// is the byte-address MSB, and its remaining odd bits form the bit index.
module hecc_locate #(
    parameter int LANES  = 3,
    parameter int LANE_W = 8,
    localparam int SYN_W = LANES * LANE_W,
    localparam int PAIRS = LANE_W / 2,
    localparam int BYTE_W = (LANES - 1) * PAIRS + 1,
    localparam int BIT_W  = PAIRS - 1
) (
    input  logic [SYN_W-1:0]  syn,
    output logic [BYTE_W-1:0] byte_idx,
    output logic [BIT_W-1:0]  bit_idx
);

    localparam int TOP = (LANES - 1) * LANE_W;

    for (genvar l = 0; l < LANES - 1; l++) begin : g_low
        for (genvar k = 0; k < PAIRS; k++) begin : g_odd
            assign byte_idx[l*PAIRS + k] = syn[l*LANE_W + 2*k + 1];
        end
    end

    assign byte_idx[BYTE_W-1] = syn[TOP + 1];

    for (genvar k = 1; k < PAIRS; k++) begin : g_bit
        assign bit_idx[k-1] = syn[TOP + 2*k + 1];
    end

    // Even-position bits carry no address; they only feed the pair test.
    logic unused_even;
    always_comb begin
        unused_even = 1'b0;
        for (int i = 0; i < SYN_W; i += 2) begin
            unused_even = unused_even ^ syn[i];
        end
    end

endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
    import hecc_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int LANE_W = 8,
    localparam int SYN_W  = LANES * LANE_W,
    localparam int PAIRS  = LANE_W / 2,
    localparam int BYTE_W = (LANES - 1) * PAIRS + 1,
    localparam int BIT_W  = PAIRS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ignore_blank,
    input  logic [SYN_W-1:0]  stored_code,
    input  logic [SYN_W-1:0]  calc_code,
    output logic [1:0]        status,
    output logic [BYTE_W-1:0] err_byte,
    output logic [BIT_W-1:0]  err_bit,
    output logic              done,
    input  logic [LANE_W-1:0] fix_in,
    input  logic [BYTE_W-1:0] fix_idx,
    output logic [LANE_W-1:0] fix_out
);

    typedef struct packed {
        hecc_status_e      verdict;
        logic [BYTE_W-1:0] byte_idx;
        logic [BIT_W-1:0]  bit_idx;
        logic              done;
    } state_t;

    state_t state_d, state_q;

    logic [SYN_W-1:0]  syn;
    logic              pairs_split, single_bit, stored_blank;
    hecc_status_e      verdict;
    logic [BYTE_W-1:0] loc_byte;
    logic [BIT_W-1:0]  loc_bit;

    hecc_syndrome #(.LANES(LANES), .LANE_W(LANE_W)) u_syn (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .syn         (syn),
        .pairs_split (pairs_split),
        .single_bit  (single_bit),
        .stored_blank(stored_blank)
    );

    hecc_classify u_cls (
        .syn_zero    (syn == '0),
        .ignore_blank(ignore_blank),
        .stored_blank(stored_blank),
        .pairs_split (pairs_split),
        .single_bit  (single_bit),
        .verdict     (verdict)
    );

    hecc_locate #(.LANES(LANES), .LANE_W(LANE_W)) u_loc (
        .syn     (syn),
        .byte_idx(loc_byte),
        .bit_idx (loc_bit)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start;
        if (start) begin
            state_d.verdict = verdict;
            if (verdict == ST_FIXED) begin
                state_d.byte_idx = loc_byte;
                state_d.bit_idx  = loc_bit;
            end else begin
                state_d.byte_idx = '0;
                state_d.bit_idx  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{verdict: ST_CLEAN, byte_idx: '0, bit_idx: '0, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    logic hit;
    assign hit = (state_q.verdict == ST_FIXED) && (fix_idx == state_q.byte_idx);

    always_comb begin
        fix_out = fix_in;
        if (hit) begin
            fix_out[state_q.bit_idx] = ~fix_in[state_q.bit_idx];
        end
    end

    assign status   = state_q.verdict;
    assign err_byte = state_q.byte_idx;
    assign err_bit  = state_q.bit_idx;
    assign done     = state_q.done;

endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk #(
    parameter int LANES  = 3,
    parameter int LANE_W = 8,
    localparam int SYN_W  = LANES * LANE_W,
    localparam int PAIRS  = LANE_W / 2,
    localparam int BYTE_W = (LANES - 1) * PAIRS + 1,
    localparam int BIT_W  = PAIRS - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ignore_blank,
    input logic [SYN_W-1:0]  stored_code,
    input logic [SYN_W-1:0]  calc_code,
    input logic [1:0]        status,
    input logic [BYTE_W-1:0] err_byte,
    input logic [BIT_W-1:0]  err_bit,
    input logic              done,
    input logic [LANE_W-1:0] fix_in,
    input logic [BYTE_W-1:0] fix_idx,
    input logic [LANE_W-1:0] fix_out
);

    p_zero_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stored_code == calc_code) |=> status == 2'b00);

    p_blank_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ignore_blank && (&stored_code)) |=> status == 2'b00);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    p_loc_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b01 |-> (err_byte == '0 && err_bit == '0));

    p_fix_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fix_out ^ fix_in) <= 1);

    p_fix_only_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_out != fix_in) |-> (status == 2'b01 && fix_idx == err_byte));

endmodule

bind hecc_corrector hecc_corrector_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ignore_blank(ignore_blank),
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit),
    .done        (done),
    .fix_in      (fix_in),
    .fix_idx     (fix_idx),
    .fix_out     (fix_out)
);

// File: tb/tb_hecc_corrector.sv
module tb_hecc_corrector;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ignore_blank = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic        done;
    logic [7:0]  fix_in = '0;
    logic [8:0]  fix_idx = '0;
    logic [7:0]  fix_out;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hecc_corrector dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ignore_blank(ignore_blank),
        .stored_code(stored_code), .calc_code(calc_code), .status(status),
        .err_byte(err_byte), .err_bit(err_bit), .done(done),
        .fix_in(fix_in), .fix_idx(fix_idx), .fix_out(fix_out)
    );

    typedef struct packed {
        logic [23:0] stored;
        logic [23:0] calc;
        logic        ign;
        logic [1:0]  st;
        logic [8:0]  byt;
        logic [2:0]  bt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{24'h123456, 24'h123456, 1'b0, 2'b00, 9'h000, 3'd0},
        '{24'hB4AD30, 24'h123456, 1'b0, 2'b01, 9'h1A5, 3'd6},
        '{24'h555555, 24'h000000, 1'b0, 2'b01, 9'h000, 3'd0},
        '{24'h000000, 24'hAAAAAA, 1'b0, 2'b01, 9'h1FF, 3'd7},
        '{24'h0F0F0F, 24'h0F070F, 1'b0, 2'b10, 9'h000, 3'd0},
        '{24'h800000, 24'h000000, 1'b1, 2'b10, 9'h000, 3'd0},
        '{24'h000003, 24'h000000, 1'b0, 2'b11, 9'h000, 3'd0},
        '{24'hFFFFFF, 24'h123456, 1'b1, 2'b00, 9'h000, 3'd0},
        '{24'hFFFFFF, 24'h000000, 1'b0, 2'b11, 9'h000, 3'd0},
        '{24'hFFFFFE, 24'h000000, 1'b1, 2'b11, 9'h000, 3'd0},
        '{24'hFFFFFF, 24'hFFFFFF, 1'b0, 2'b00, 9'h000, 3'd0},
        '{24'h555554, 24'h000000, 1'b0, 2'b11, 9'h000, 3'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] s, input logic [23:0] c, input logic ig);
        @(negedge clk);
        stored_code  = s;
        calc_code    = c;
        ignore_blank = ig;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Syndrome for a data error at (byt, bt), built from the R4/R5 mapping.
    function automatic logic [23:0] make_syn(input logic [8:0] byt, input logic [2:0] bt);
        logic [7:0] d0, d1, d2;
        for (int k = 0; k < 4; k++) begin
            d0[2*k+1] = byt[k];     d0[2*k] = ~byt[k];
            d1[2*k+1] = byt[4+k];   d1[2*k] = ~byt[4+k];
        end
        d2[1] = byt[8]; d2[0] = ~byt[8];
        for (int k = 1; k < 4; k++) begin
            d2[2*k+1] = bt[k-1]; d2[2*k] = ~bt[k-1];
        end
        return {d2, d1, d0};
    endfunction

    function automatic string st_tag(input logic [1:0] st);
        case (st)
            2'b00:   return "R1/R2 status";
            2'b01:   return "R3 status";
            2'b10:   return "R6 status";
            default: return "R7 status";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 status", 32'(status), 32'd0);
        check("R10 err_byte", 32'(err_byte), 32'd0);
        check("R10 done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 err_bit", 32'(err_bit), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].stored, VEC[i].calc, VEC[i].ign);
            check("R8 done", 32'(done), 32'd1);
            check(st_tag(VEC[i].st), 32'(status), 32'(VEC[i].st));
            check("R5/R11 err_byte", 32'(err_byte), 32'(VEC[i].byt));
            check("R4/R11 err_bit", 32'(err_bit), 32'(VEC[i].bt));
        end

        // R9: correction at and beside the location of vector 1
        run(24'hB4AD30, 24'h123456, 1'b0);
        fix_in = 8'h00; fix_idx = 9'h1A5; #1;
        check("R9 hit", 32'(fix_out), 32'h40);
        fix_idx = 9'h1A4; #1;
        check("R9 miss", 32'(fix_out), 32'h00);
        @(negedge clk);
        check("R8 done drop", 32'(done), 32'd0);

        // R8: no start, inputs change, outputs hold
        stored_code = 24'h000003; calc_code = 24'h0; ignore_blank = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hold status", 32'(status), 32'd1);
        check("R8 hold byte", 32'(err_byte), 32'h1A5);

        // R9: code-only error leaves the byte at index 0 untouched
        run(24'h800000, 24'h000000, 1'b0);
        fix_in = 8'hFF; fix_idx = 9'h000; #1;
        check("R9 code-only pass", 32'(fix_out), 32'hFF);

        // R4/R5/R9: sweep of locations
        for (int i = 0; i < 16; i++) begin
            logic [8:0] byt;
            logic [2:0] bt;
            logic [23:0] c;
            byt = 9'((i * 37 + 5) % 512);
            bt  = 3'(i % 8);
            c   = 24'(i * 24'h1357);
            run(c ^ make_syn(byt, bt), c, 1'b0);
            check("R3 sweep status", 32'(status), 32'd1);
            check("R5 sweep byte", 32'(err_byte), 32'(byt));
            check("R4 sweep bit", 32'(err_bit), 32'(bt));
            fix_in = 8'hA5; fix_idx = byt; #1;
            check("R9 sweep fix", 32'(fix_out), 32'(8'hA5 ^ (8'h01 << bt)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule